// File: doc/BRIEF.md
# Three-Wire Byte Acceptor

This block is the receiving end of an interlocked, open-collector byte handshake on an eight-bit parallel instrument bus. The talker drives a data-valid strobe; every receiver shares two active-low back-pressure wires by wired-AND. One wire says "not ready for data" and the other says "data not yet accepted". The block drives only pull-low enables for those two wires. It reads the resolved levels of the strobe, the attention line, the end-of-message line and the eight data lines.

Each accepted byte goes into a small FIFO. The byte carries two flags: whether it arrived while attention was asserted (a command byte) and whether end-of-message was asserted with it. The FIFO drains through a local valid/ready port. The block takes part in data-byte transfers only when the surrounding logic has addressed it to listen. It always accepts bytes sent under attention. It offers readiness only while the FIFO has room. All line inputs pass through a short synchronizer before use.

Top module: `byte_acceptor`

## Requirements
- R1: After reset the FIFO is empty (`out_valid_o` low). With attention high (`atn_n_i`=1) and `listen_en_i` low, neither pull-low enable is active.
- R2: While taking part and waiting for a byte, the block pulls the not-accepted wire low (`ndac_pull_o`=1). It releases the not-ready wire only when the FIFO has room and the strobe is high (`dav_n_i`=1).
- R3: When the synchronized strobe goes low and there is room, the block captures the byte and pulls the not-ready wire low. It then releases the not-accepted wire and holds that state until the strobe returns high.
- R4: Once the strobe returns high after an accepted byte, the block pulls the not-accepted wire low again and becomes ready for the next byte.
- R5: `out_last_o` is 1 for a byte that was captured while `eoi_n_i` was 0, and 0 otherwise.
- R6: While `atn_n_i` is 0 the block accepts bytes whatever the value of `listen_en_i`, and marks each one with `out_cmd_o`=1. Bytes taken with `atn_n_i`=1 carry `out_cmd_o`=0.
- R7: With `atn_n_i`=1 and `listen_en_i`=0 the block releases both wires and captures nothing, even while the strobe is low.
- R8: Captured bytes come out in arrival order from a FIFO of `DEPTH` entries (default 4). While the FIFO is full, the not-ready wire stays pulled low.
- R9: An entry leaves the FIFO only on a cycle with `out_valid_o` and `out_ready_i` both high. While valid is held without ready, the output entry does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| listen_en_i | input | 1 | Block is addressed to listen |
| atn_n_i | input | 1 | Resolved attention line, low = command phase |
| eoi_n_i | input | 1 | Resolved end-of-message line, low = last byte |
| dav_n_i | input | 1 | Resolved data-valid strobe, low = byte on bus |
| dio_i | input | DW | Resolved data lines, taken as the byte value |
| nrfd_pull_o | output | 1 | 1 = pull the not-ready wire low |
| ndac_pull_o | output | 1 | 1 = pull the not-accepted wire low |
| out_valid_o | output | 1 | FIFO head is valid |
| out_ready_i | input | 1 | Consumer takes the FIFO head |
| out_data_o | output | DW | Byte at FIFO head |
| out_last_o | output | 1 | Head byte ended a message |
| out_cmd_o | output | 1 | Head byte was a command byte |

## Verification
The bench drives all 256 byte values through a talker model that waits on the two wires. A consumer with an irregular ready pattern drains the FIFO, so it fills and empties many times. Some stretches of the sweep run under attention, and one of them runs with the listen enable off. A design that captured a byte twice per strobe, lost the end or command flag, or reordered entries would produce miscompares against the expected stream. The bench also holds the strobe low while the block is not addressed; a block that captured bytes it was not addressed for would raise valid. It fills the FIFO with the consumer stopped; a block that offered readiness while full would release the not-ready wire. Each wait on a wire has a timeout, so a block that never re-pulls the not-accepted wire after the strobe returns high is reported rather than hanging the run.

// File: rtl/byte_acceptor.sv
module byte_acceptor #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  parameter int SYNC  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          listen_en_i,
  input  logic          atn_n_i,
  input  logic          eoi_n_i,
  input  logic          dav_n_i,
  input  logic [DW-1:0] dio_i,
  output logic          nrfd_pull_o,
  output logic          ndac_pull_o,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [DW-1:0] out_data_o,
  output logic          out_last_o,
  output logic          out_cmd_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int LW = DW + 3;
  localparam int EW = DW + 2;

  logic [LW-1:0] pipe [SYNC];
  logic [LW-1:0] ln;
  logic          dav_lo, eoi_lo, atn_lo;
  logic          take_part, accepted, room, push, pop;
  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) pipe[i] <= '1;
    end else begin
      pipe[0] <= {atn_n_i, eoi_n_i, dav_n_i, dio_i};
      for (int i = 1; i < SYNC; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign ln        = pipe[SYNC-1];
  assign dav_lo    = !ln[DW];
  assign eoi_lo    = !ln[DW+1];
  assign atn_lo    = !ln[DW+2];
  assign take_part = atn_lo || listen_en_i;
  assign room      = (count != CW'(DEPTH));
  assign push      = take_part && !accepted && dav_lo && room;
  assign pop       = out_valid_o && out_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   accepted <= 1'b0;
    else if (!take_part)          accepted <= 1'b0;
    else if (push)                accepted <= 1'b1;
    else if (accepted && !dav_lo) accepted <= 1'b0;
  end

  assign nrfd_pull_o = take_part && (accepted || !room || dav_lo);
  assign ndac_pull_o = take_part && !accepted;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {atn_lo, eoi_lo, ln[DW-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  assign out_valid_o = (count != '0);
  assign {out_cmd_o, out_last_o, out_data_o} = mem[rp];
endmodule

// File: rtl/byte_acceptor_chk.sv
module byte_acceptor_chk #(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          take_part,
  input logic          push,
  input logic [CW-1:0] count,
  input logic          nrfd_pull_o,
  input logic          ndac_pull_o,
  input logic          out_valid_o,
  input logic          out_ready_i,
  input logic [DW-1:0] out_data_o,
  input logic          out_last_o,
  input logic          out_cmd_o
);
  assert_one_wire_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take_part |-> (nrfd_pull_o || ndac_pull_o));

  assert_capture_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (nrfd_pull_o || !take_part));

  assert_full_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take_part && count == CW'(DEPTH)) |-> nrfd_pull_o);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_head_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable({out_cmd_o, out_last_o, out_data_o})));
endmodule

bind byte_acceptor byte_acceptor_chk #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .take_part(take_part), .push(push), .count(count),
  .nrfd_pull_o(nrfd_pull_o), .ndac_pull_o(ndac_pull_o),
  .out_valid_o(out_valid_o), .out_ready_i(out_ready_i),
  .out_data_o(out_data_o), .out_last_o(out_last_o), .out_cmd_o(out_cmd_o)
);

// File: tb/byte_acceptor_tb.sv
module byte_acceptor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 0, rst_n = 0;
  logic listen_en = 0, atn_n = 1, eoi_n = 1, dav_n = 1;
  logic [DW-1:0] dio = '0;
  logic nrfd_pull, ndac_pull, out_valid, out_ready = 0, out_last, out_cmd;
  logic [DW-1:0] out_data;

  int nvec = 0, nfail = 0;
  int wr_idx = 0, rd_idx = 0, cyc = 0;
  bit sink_en = 0, done = 0;
  logic [DW+1:0] exp_q [0:511];

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_acceptor u_dut (
    .clk(clk), .rst_n(rst_n), .listen_en_i(listen_en), .atn_n_i(atn_n),
    .eoi_n_i(eoi_n), .dav_n_i(dav_n), .dio_i(dio),
    .nrfd_pull_o(nrfd_pull), .ndac_pull_o(ndac_pull),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_data_o(out_data), .out_last_o(out_last), .out_cmd_o(out_cmd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  logic [DW+1:0] held;
  bit held_v = 0;
  always @(negedge clk) begin
    bit r;
    cyc++;
    if (held_v) chk(out_valid && {out_cmd, out_last, out_data} == held,
                    "R9 head stable", {out_cmd, out_last, out_data}, held);
    r = sink_en && (cyc % 5 != 2) && (cyc % 11 != 4);
    if (out_valid && r) begin
      chk({out_cmd, out_last, out_data} == exp_q[rd_idx], "R5 R6 R8 stream",
          {out_cmd, out_last, out_data}, exp_q[rd_idx]);
      rd_idx++;
    end
    held_v = out_valid && !r;
    held   = {out_cmd, out_last, out_data};
    out_ready = r;
  end

  task automatic wait_for(input bit want_nrfd, input bit val, input string req);
    int t = 0;
    while (((want_nrfd ? nrfd_pull : ndac_pull) != val) && t < 100) begin
      @(negedge clk); t++;
    end
    chk(t < 100, req, want_nrfd ? nrfd_pull : ndac_pull, val);
  endtask

  task automatic send(input logic [DW-1:0] d, input bit eoi, input bit atn);
    if (atn_n != !atn) begin
      atn_n = !atn;
      repeat (4) @(negedge clk);
    end
    wait_for(1, 0, "R2 nrfd released when room");
    chk(ndac_pull == 1, "R2 ndac held while waiting", ndac_pull, 1);
    dio = d; eoi_n = !eoi;
    @(negedge clk);
    exp_q[wr_idx] = {atn, eoi, d}; wr_idx++;
    dav_n = 0;
    wait_for(0, 0, "R3 ndac released on accept");
    chk(nrfd_pull == 1, "R3 nrfd held after capture", nrfd_pull, 1);
    dav_n = 1; eoi_n = 1;
    wait_for(0, 1, "R4 ndac re-pulled after strobe");
  endtask

  task automatic drain;
    int t = 0;
    while (rd_idx != wr_idx && t < 500) begin @(negedge clk); t++; end
    chk(rd_idx == wr_idx, "R8 drain", rd_idx, wr_idx);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R1 empty after reset", out_valid, 0);
    chk(nrfd_pull == 0 && ndac_pull == 0, "R1 lines released", {nrfd_pull, ndac_pull}, 0);

    listen_en = 1;
    @(negedge clk);
    chk(ndac_pull == 1 && nrfd_pull == 0, "R2 idle listener", {nrfd_pull, ndac_pull}, 1);

    sink_en = 1;
    for (int i = 0; i < 256; i++) send(DW'(i), (i % 7) == 6, (i % 16) < 3);
    listen_en = 0;
    for (int i = 0; i < 16; i++) send(DW'(8'hF0 ^ (i * 13)), i == 15, 1'b1);
    drain();

    atn_n = 1;
    repeat (4) @(negedge clk);
    chk(nrfd_pull == 0 && ndac_pull == 0, "R7 unaddressed releases", {nrfd_pull, ndac_pull}, 0);
    dio = 8'hA5; dav_n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(out_valid == 0 && ndac_pull == 0, "R7 nothing captured", out_valid, 0);
    end
    dav_n = 1;
    repeat (4) @(negedge clk);

    listen_en = 1;
    sink_en = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 4; i++) send(DW'(8'h30 + i), i == 3, 1'b0);
    repeat (6) @(negedge clk);
    chk(nrfd_pull == 1, "R8 full holds nrfd", nrfd_pull, 1);
    chk(out_valid == 1 && out_data == 8'h30, "R9 head held without ready", out_data, 8'h30);
    sink_en = 1;
    wait_for(1, 0, "R8 nrfd freed after pop");
    drain();
    chk(out_valid == 0, "R8 empty at end", out_valid, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule